// File: doc/BRIEF.md
# PLL clock control and selection unit

This block decides which clock source drives the system. It keeps a small configuration register: a reference-halving bit, a 2-bit multiplier code, a 3-bit divider code, a free-run bit and a source-select bit. From these it derives the reference enable, the PLL enable, and the PLL multiply and divide ratios for a behavioural PLL model outside the block. It also derives the safety-clock divisor.

One source gate out of four is raised: reference, PLL, free-running or safety. The PLL gate needs the select bit, a running PLL, the lock input and the supply-ready input. The free-running gate needs the select bit, the PLL-off divider code and the free-run bit, but not lock. While the PLL is gated, the PLL clock is watched through a synchronizer. If no PLL edge arrives for a set number of reference ticks, a sticky fallback flag forces the safety gate until software clears it.

The source state machine has the states REF, PLL, FREE, SAFE and HAND. From any of the four source states, a change in the wanted source takes it to HAND (the *switch* transition), with all gates low. After a fixed gap, HAND moves to the state of whatever source is wanted at that moment (the *settle* transition).

Top module: `pll_ccu_top`

## Requirements
- R1: After reset the halving bit is 1, the divider code is 111 (PLL off), the multiplier code is 00, select and free-run are 0, the reference gate (gate_o bit 0) is the only gate high, and fallback_o is 0.
- R2: With the halving bit set, ref_en_o is high on every second clock. With it cleared, ref_en_o is high on every clock.
- R3: Multiplier codes 0, 1, 2, 3 give pll_mul_o values 6, 8, 10, 14.
- R4: Divider codes 0 to 6 give pll_en_o=1 and pll_div_o = code+1. Code 111 gives pll_en_o=0 and pll_div_o=0.
- R5: The PLL gate (bit 1) is raised only when select=1, the divider code is not 111, lock_i=1 and supply_ok_i=1. Otherwise, without fallback or free-run, the reference gate is used.
- R6: The free-running gate (bit 2) is raised when select=1, the divider code is 111 and free-run=1, whatever lock_i is.
- R7: The free-run field of a write is dropped when the select bit held before that write is 1.
- R8: safe_div_o is 10, 12, 14, 16, 2, 4, 6, 8 for divider codes 000 to 111.
- R9: While the PLL gate is up, if LOSS_LIM reference ticks pass with no PLL edge, fallback_o sets and the safety gate (bit 3) is raised. Both persist whatever the configuration is, until fb_clr_i.
- R10: Between two different sources, all gates are low for exactly 2*SYNC_STAGES clocks.
- R11: At most one gate is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | oscillator clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_we_i | input | 1 | configuration write strobe |
| cfg_div2_i | input | 1 | reference halving bit |
| cfg_mul_i | input | 2 | multiplier code |
| cfg_div_i | input | 3 | divider code, 111 = PLL off |
| cfg_free_i | input | 1 | free-run bit |
| cfg_sel_i | input | 1 | source-select bit |
| fb_clr_i | input | 1 | clears the fallback flag |
| lock_i | input | 1 | PLL lock status |
| supply_ok_i | input | 1 | regulator supply stable |
| pll_clk_i | input | 1 | PLL clock, watched for loss |
| ref_en_o | output | 1 | reference tick enable |
| pll_en_o | output | 1 | PLL run enable |
| pll_mul_o | output | 4 | PLL multiply ratio |
| pll_div_o | output | 3 | PLL post-divide ratio |
| safe_div_o | output | 5 | safety clock divisor |
| gate_o | output | 4 | source gates: 0 ref, 1 PLL, 2 free-run, 3 safety |
| fallback_o | output | 1 | sticky clock-loss flag |

## Verification
The bench uses the default values, SYNC_STAGES=2 and LOSS_LIM=16. These give a handoff gap of four clocks, which can be counted exactly. With the halving bit set, a stopped PLL clock is detected within about forty clocks. That is short enough that the loss, the sticky hold and the clearing of the fallback all run in one directed sequence after the vector table.

// File: rtl/pll_ccu_pkg.sv
package pll_ccu_pkg;
    localparam logic [2:0] PLL_OFF_CODE = 3'b111;

    typedef enum logic [2:0] {ST_REF, ST_PLL, ST_FREE, ST_SAFE, ST_HAND} ccu_state_e;
    typedef enum logic [1:0] {SRC_REF, SRC_PLL, SRC_FREE, SRC_SAFE} src_e;

    typedef struct packed {
        logic       div2;
        logic [1:0] mul;
        logic [2:0] div;
        logic       free;
        logic       sel;
    } ccu_cfg_t;
endpackage

// File: rtl/ccu_cfg_regs.sv
module ccu_cfg_regs
    import pll_ccu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  ccu_cfg_t   wr,
    output ccu_cfg_t   cfg_q,
    output logic       ref_en_o,
    output logic       pll_en_o,
    output logic [3:0] mul_o,
    output logic [2:0] div_o,
    output logic [4:0] safe_o
);
    localparam ccu_cfg_t CFG_RST = '{div2: 1'b1, mul: 2'd0, div: PLL_OFF_CODE,
                                     free: 1'b0, sel: 1'b0};
    logic tog_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else if (we) begin
            cfg_q.div2 <= wr.div2;
            cfg_q.mul  <= wr.mul;
            cfg_q.div  <= wr.div;
            cfg_q.sel  <= wr.sel;
            if (!cfg_q.sel) cfg_q.free <= wr.free;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    assign ref_en_o = ~cfg_q.div2 | tog_q;
    assign pll_en_o = (cfg_q.div != PLL_OFF_CODE);

    always_comb begin
        unique case (cfg_q.mul)
            2'd0:    mul_o = 4'd6;
            2'd1:    mul_o = 4'd8;
            2'd2:    mul_o = 4'd10;
            default: mul_o = 4'd14;
        endcase
        div_o  = pll_en_o ? 3'(cfg_q.div + 3'd1) : 3'd0;
        safe_o = cfg_q.div[2] ? 5'(({3'd0, cfg_q.div[1:0]} + 5'd1) << 1)
                              : 5'(5'd10 + {2'd0, cfg_q.div[1:0], 1'b0});
    end

    p_free_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && cfg_q.sel) |=> $stable(cfg_q.free));
    p_half_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.div2 && ref_en_o) |=> (!ref_en_o || !cfg_q.div2));
endmodule

// File: rtl/ccu_loss_det.sv
module ccu_loss_det #(
    parameter int SYNC_STAGES = 2,
    parameter int LOSS_LIM    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_clk_i,
    input  logic ref_en,
    input  logic pll_active,
    input  logic clr,
    output logic fb_o
);
    localparam int CW = $clog2(LOSS_LIM + 1);
    logic [SYNC_STAGES:0] sh_q;
    logic [CW-1:0]        cnt_q;
    logic                 pll_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_STAGES-1:0], pll_clk_i};
    end
    assign pll_edge = sh_q[SYNC_STAGES] ^ sh_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (!pll_active || pll_edge) cnt_q <= '0;
        else if (ref_en)                 cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   fb_o <= 1'b0;
        else if (clr) fb_o <= 1'b0;
        else if (pll_active && !pll_edge && ref_en && cnt_q == CW'(LOSS_LIM - 1))
            fb_o <= 1'b1;
    end

    p_loss_only_on_pll_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fb_o) |-> $past(pll_active));
    p_loss_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_o && !clr) |=> fb_o);
endmodule

// File: rtl/ccu_src_fsm.sv
module ccu_src_fsm
    import pll_ccu_pkg::*;
#(
    parameter int GAP = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  src_e       want,
    output logic [3:0] gate_o,
    output logic       pll_on_o
);
    localparam int CW = $clog2(GAP + 1);
    ccu_state_e st_q, st_d;
    logic [CW-1:0] cnt_q;

    function automatic ccu_state_e st_of(src_e s);
        case (s)
            SRC_PLL:  return ST_PLL;
            SRC_FREE: return ST_FREE;
            SRC_SAFE: return ST_SAFE;
            default:  return ST_REF;
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_REF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_q == ST_HAND) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_REF:  if (want != SRC_REF)  st_d = ST_HAND;
            ST_PLL:  if (want != SRC_PLL)  st_d = ST_HAND;
            ST_FREE: if (want != SRC_FREE) st_d = ST_HAND;
            ST_SAFE: if (want != SRC_SAFE) st_d = ST_HAND;
            ST_HAND: if (cnt_q == CW'(GAP - 1)) st_d = st_of(want);
            default: st_d = ST_HAND;
        endcase
    end

    always_comb begin
        gate_o = 4'b0000;
        unique case (st_q)
            ST_REF:  gate_o[0] = 1'b1;
            ST_PLL:  gate_o[1] = 1'b1;
            ST_FREE: gate_o[2] = 1'b1;
            ST_SAFE: gate_o[3] = 1'b1;
            default: gate_o = 4'b0000;
        endcase
    end
    assign pll_on_o = (st_q == ST_PLL);

    p_one_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_o));
    p_break_before_make_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o != 4'b0000 && $past(gate_o) != 4'b0000) |-> gate_o == $past(gate_o));
endmodule

// File: rtl/pll_ccu_top.sv
module pll_ccu_top
    import pll_ccu_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOSS_LIM    = 16
) (
    input  logic       clk_osc,
    input  logic       rst_n,
    input  logic       cfg_we_i,
    input  logic       cfg_div2_i,
    input  logic [1:0] cfg_mul_i,
    input  logic [2:0] cfg_div_i,
    input  logic       cfg_free_i,
    input  logic       cfg_sel_i,
    input  logic       fb_clr_i,
    input  logic       lock_i,
    input  logic       supply_ok_i,
    input  logic       pll_clk_i,
    output logic       ref_en_o,
    output logic       pll_en_o,
    output logic [3:0] pll_mul_o,
    output logic [2:0] pll_div_o,
    output logic [4:0] safe_div_o,
    output logic [3:0] gate_o,
    output logic       fallback_o
);
    localparam int HAND_GAP = 2 * SYNC_STAGES;

    ccu_cfg_t wr_s, cfg_s;
    src_e     want;
    logic     pll_gated;

    assign wr_s = '{div2: cfg_div2_i, mul: cfg_mul_i, div: cfg_div_i,
                    free: cfg_free_i, sel: cfg_sel_i};

    ccu_cfg_regs i_regs (
        .clk(clk_osc), .rst_n(rst_n), .we(cfg_we_i), .wr(wr_s), .cfg_q(cfg_s),
        .ref_en_o(ref_en_o), .pll_en_o(pll_en_o), .mul_o(pll_mul_o),
        .div_o(pll_div_o), .safe_o(safe_div_o)
    );

    ccu_loss_det #(.SYNC_STAGES(SYNC_STAGES), .LOSS_LIM(LOSS_LIM)) i_loss (
        .clk(clk_osc), .rst_n(rst_n), .pll_clk_i(pll_clk_i), .ref_en(ref_en_o),
        .pll_active(pll_gated), .clr(fb_clr_i), .fb_o(fallback_o)
    );

    always_comb begin
        if (fallback_o)
            want = SRC_SAFE;
        else if (cfg_s.sel && pll_en_o && lock_i && supply_ok_i)
            want = SRC_PLL;
        else if (cfg_s.sel && !pll_en_o && cfg_s.free)
            want = SRC_FREE;
        else
            want = SRC_REF;
    end

    ccu_src_fsm #(.GAP(HAND_GAP)) i_fsm (
        .clk(clk_osc), .rst_n(rst_n), .want(want), .gate_o(gate_o), .pll_on_o(pll_gated)
    );

    p_pll_needs_lock_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $rose(gate_o[1]) |-> $past(cfg_s.sel && pll_en_o && lock_i && supply_ok_i));
    p_free_needs_off_r6: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $rose(gate_o[2]) |-> $past(cfg_s.sel && !pll_en_o && cfg_s.free));
endmodule

// File: tb/test_pll_ccu_top.sv
`timescale 1ns/1ps
module test_pll_ccu_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic we = 0, div2 = 1, free = 0, sel = 0, fb_clr = 0, lock = 0, sup = 0, pll_clk = 0;
    logic [1:0] mul = 0;
    logic [2:0] div = 3'b111;
    logic ref_en, pll_en, fallback;
    logic [3:0] pmul, gate;
    logic [2:0] pdiv;
    logic [4:0] sdiv;
    logic pll_run = 1'b1, done = 1'b0;
    int nchk = 0, nfail = 0, bad1h = 0;

    always #4 clk = ~clk;

    pll_ccu_top i_pll_ccu_top (
        .clk_osc(clk), .rst_n(rst_n), .cfg_we_i(we), .cfg_div2_i(div2), .cfg_mul_i(mul),
        .cfg_div_i(div), .cfg_free_i(free), .cfg_sel_i(sel), .fb_clr_i(fb_clr),
        .lock_i(lock), .supply_ok_i(sup), .pll_clk_i(pll_clk), .ref_en_o(ref_en),
        .pll_en_o(pll_en), .pll_mul_o(pmul), .pll_div_o(pdiv), .safe_div_o(sdiv),
        .gate_o(gate), .fallback_o(fallback)
    );

    always @(negedge clk) if (pll_run) pll_clk <= ~pll_clk;
    always @(negedge clk) if (rst_n && $countones(gate) > 1) bad1h++;

    // stimulus {div2,mul,div,free,sel,lock,sup} ; expected {gate,pll_en,mul,div,safe}
    localparam logic [26:0] VEC [0:9] = '{
        {1'b1,2'd0,3'd7,1'b0,1'b0,1'b0,1'b0, 4'b0001,1'b0,4'd6, 3'd0,5'd8},
        {1'b1,2'd1,3'd0,1'b0,1'b1,1'b1,1'b1, 4'b0010,1'b1,4'd8, 3'd1,5'd10},
        {1'b0,2'd2,3'd3,1'b0,1'b1,1'b0,1'b1, 4'b0001,1'b1,4'd10,3'd4,5'd16},
        {1'b1,2'd3,3'd6,1'b0,1'b1,1'b1,1'b0, 4'b0001,1'b1,4'd14,3'd7,5'd6},
        {1'b1,2'd0,3'd7,1'b1,1'b1,1'b0,1'b0, 4'b0100,1'b0,4'd6, 3'd0,5'd8},
        {1'b1,2'd2,3'd5,1'b1,1'b1,1'b1,1'b1, 4'b0010,1'b1,4'd10,3'd6,5'd4},
        {1'b1,2'd1,3'd4,1'b0,1'b0,1'b1,1'b1, 4'b0001,1'b1,4'd8, 3'd5,5'd2},
        {1'b0,2'd3,3'd1,1'b0,1'b1,1'b1,1'b1, 4'b0010,1'b1,4'd14,3'd2,5'd12},
        {1'b1,2'd0,3'd2,1'b0,1'b1,1'b1,1'b1, 4'b0010,1'b1,4'd6, 3'd3,5'd14},
        {1'b1,2'd1,3'd7,1'b0,1'b1,1'b1,1'b1, 4'b0001,1'b0,4'd8, 3'd0,5'd8}
    };

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic d2, input logic [1:0] m, input logic [2:0] d,
                      input logic f, input logic s);
        div2 = d2; mul = m; div = d; free = f; sel = s; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        if (!done) finish_run();
    end

    initial begin
        int cnt, zeros;
        logic [26:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk("R1 gate", gate, 4'b0001);
        chk("R1 pll_en", pll_en, 0);
        chk("R1 fallback", fallback, 0);
        chk("R1 mul", pmul, 6);
        chk("R1 safe", sdiv, 8);
        // R2 halved reference
        cnt = 0;
        for (int k = 0; k < 10; k++) begin if (ref_en) cnt++; @(negedge clk); end
        chk("R2 halved", cnt, 5);

        for (int i = 0; i < 10; i++) begin
            v = VEC[i];
            lock = v[18]; sup = v[17];
            wr(v[26], v[25:24], v[23:21], v[20], 1'b0);
            wr(v[26], v[25:24], v[23:21], v[20], 1'b0);
            wr(v[26], v[25:24], v[23:21], v[20], v[19]);
            idle(14);
            chk($sformatf("R5/R6 gate row%0d", i), gate, v[16:13]);
            chk($sformatf("R4 pll_en row%0d", i), pll_en, v[12]);
            chk($sformatf("R3 mul row%0d", i), pmul, v[11:8]);
            chk($sformatf("R4 div row%0d", i), pdiv, v[7:5]);
            chk($sformatf("R8 safe row%0d", i), sdiv, v[4:0]);
        end

        // R2 undivided reference
        wr(1'b0, 2'd0, 3'd7, 1'b0, 1'b0);
        idle(2);
        cnt = 0;
        for (int k = 0; k < 10; k++) begin if (ref_en) cnt++; @(negedge clk); end
        chk("R2 undivided", cnt, 10);

        // R10 handoff gap, R6 free-run with lock low
        lock = 1'b0; sup = 1'b0;
        wr(1'b1, 2'd0, 3'd7, 1'b0, 1'b0);
        idle(12);
        wr(1'b1, 2'd0, 3'd7, 1'b1, 1'b1);
        zeros = 0;
        for (int k = 0; k < 12; k++) begin if (gate == 4'b0000) zeros++; @(negedge clk); end
        chk("R10 gap", zeros, 4);
        chk("R6 free gate", gate, 4'b0100);

        // R7 free-run write dropped while select held
        wr(1'b1, 2'd0, 3'd7, 1'b0, 1'b1);
        zeros = 0;
        for (int k = 0; k < 12; k++) begin if (gate == 4'b0000) zeros++; @(negedge clk); end
        chk("R7 gate kept", gate, 4'b0100);
        chk("R7 no handoff", zeros, 0);

        // R9 clock loss
        lock = 1'b1; sup = 1'b1;
        wr(1'b1, 2'd1, 3'd0, 1'b0, 1'b0);
        wr(1'b1, 2'd1, 3'd0, 1'b0, 1'b1);
        idle(14);
        chk("R9 pll before loss", gate, 4'b0010);
        chk("R9 flag before loss", fallback, 0);
        pll_run = 1'b0;
        idle(80);
        chk("R9 safe gate", gate, 4'b1000);
        chk("R9 flag set", fallback, 1);
        pll_run = 1'b1;
        wr(1'b1, 2'd1, 3'd0, 1'b0, 1'b0);
        idle(12);
        chk("R9 sticky gate", gate, 4'b1000);
        chk("R9 sticky flag", fallback, 1);
        fb_clr = 1'b1;
        @(negedge clk);
        fb_clr = 1'b0;
        idle(12);
        chk("R9 cleared flag", fallback, 0);
        chk("R9 back to ref", gate, 4'b0001);

        chk("R11 one gate", bad1h, 0);
        finish_run();
    end
endmodule